// File: doc/BRIEF.md
# Destination Address Filter for a Received Ethernet Byte Stream

This block sits behind a media-independent receive front end that has already joined nibbles into bytes and removed the preamble and start delimiter. It sees the frame as a byte stream with three framing strobes: one marks the start of a frame, one marks its end, and one flags a receive error. The first six bytes of each frame form the destination address. The block checks that address against one station address, which is fixed at build time, and against the all-ones broadcast address.

The address is compared one byte at a time while it arrives. One running match flag is kept for each accepted pattern, so the block needs no six-byte holding register. When the frame ends, the block gives a single one-cycle acceptance pulse. It does so only if all six address bytes arrived, one of the two patterns matched every byte, and no error was flagged during the frame. The source address, EtherType and payload pass by without effect.

Top module: `da_filter`

## Requirements
- R1: While reset is high and on the cycle after reset, `frame_valid` is 0.
- R2: After `frame_start`, the first six bytes taken with `rx_byte_valid` high form the destination address, most significant byte first (byte 0 is the leftmost byte in colon notation). If they equal `STATION_ADDR` (default 00:0A:35:02:AF:9A), `frame_valid` is 1 for exactly one cycle. That cycle is the one after `frame_end` is sampled.
- R3: A destination address of FF:FF:FF:FF:FF:FF is accepted in the same way as R2.
- R4: A destination address that differs from both patterns in any single byte, including the last one, produces no pulse.
- R5: If `rx_err` is high in any cycle from `frame_start` through `frame_end`, both inclusive, the frame produces no pulse.
- R6: A frame that ends after fewer than six bytes produces no pulse, even if every byte received matches.
- R7: Bytes after the sixth have no effect on the decision, whatever their values.
- R8: A `frame_start` in the middle of a frame discards that frame. Only the frame that follows it is judged.
- R9: A `frame_end` produces no pulse unless a `frame_start` has occurred since the last `frame_end` (or since reset). At most one pulse is given per frame.
- R10: Cycles where `rx_byte_valid` is low do not advance the byte position.
- R11: An address that takes some bytes from the station address and others from the broadcast pattern is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_byte | input | 8 | Received byte that follows the start delimiter |
| rx_byte_valid | input | 1 | `rx_byte` carries a byte in this cycle |
| frame_start | input | 1 | One-cycle strobe that opens a frame, sent before its first byte |
| frame_end | input | 1 | One-cycle strobe that closes a frame, sent after its last byte |
| rx_err | input | 1 | Receive error reported in this cycle |
| frame_valid | output | 1 | One-cycle pulse for a frame that was accepted |

## Verification
The assertions assume that the framing strobes are single-cycle pulses. They also assume that `frame_start` and `frame_end` never fall in the same cycle, and that no byte is presented in the same cycle as either strobe. Under those assumptions, every pulse must come directly after a `frame_end`, must follow a full six-byte count, and must not follow an error cycle. The bench driver builds each frame in a fixed sequence: a start strobe, then the bytes (with optional idle gaps), then an end strobe, then an idle cycle. This keeps every stimulus within those assumptions. The only deliberate breaks in the sequence are a restart in the middle of a frame and end strobes with no frame open.

// File: rtl/da_filt_pkg.sv
package da_filt_pkg;

    localparam int ADDR_BYTES = 6;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
    localparam int NUM_PAT    = 2;

    typedef logic [7:0]              octet_t;
    typedef logic [CNT_W-1:0]        pos_t;
    typedef logic [8*ADDR_BYTES-1:0] mac_t;

    localparam mac_t BCAST_ADDR   = '1;
    localparam pos_t ADDR_DONE    = pos_t'(ADDR_BYTES);

    typedef struct packed {
        logic   start;
        logic   fin;
        logic   vld;
        logic   err;
        octet_t data;
    } rx_beat_t;

    // Octet at wire position idx, most significant octet sent first.
    function automatic octet_t pick_octet(mac_t a, pos_t idx);
        int sh;
        if (int'(idx) >= ADDR_BYTES) return '0;
        sh = 8 * (ADDR_BYTES - 1 - int'(idx));
        return octet_t'(a >> sh);
    endfunction

endpackage

// File: rtl/da_pos_counter.sv
module da_pos_counter
    import da_filt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rx_beat_t beat,
    output pos_t     pos
);
    always_ff @(posedge clk) begin
        if (rst)
            pos <= '0;
        else if (beat.start)
            pos <= '0;
        else if (beat.vld && pos != ADDR_DONE)
            pos <= pos + pos_t'(1);
    end
endmodule

// File: rtl/da_pattern_track.sv
module da_pattern_track
    import da_filt_pkg::*;
#(
    parameter mac_t PATTERN = '1
) (
    input  logic     clk,
    input  logic     rst,
    input  rx_beat_t beat,
    input  pos_t     pos,
    output logic     hit
);
    logic in_addr;
    assign in_addr = (pos != ADDR_DONE);

    always_ff @(posedge clk) begin
        if (rst)
            hit <= 1'b0;
        else if (beat.start)
            hit <= 1'b1;
        else if (beat.fin)
            hit <= 1'b0;
        else if (beat.vld && in_addr && beat.data != pick_octet(PATTERN, pos))
            hit <= 1'b0;
    end
endmodule

// File: rtl/da_verdict.sv
module da_verdict
    import da_filt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rx_beat_t beat,
    input  pos_t     pos,
    input  logic     hit_any,
    output logic     frame_valid
);
    logic err_seen;

    always_ff @(posedge clk) begin
        if (rst)
            err_seen <= 1'b0;
        else if (beat.start)
            err_seen <= beat.err;
        else if (beat.err)
            err_seen <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            frame_valid <= 1'b0;
        else
            frame_valid <= beat.fin && !beat.start && (pos == ADDR_DONE)
                           && hit_any && !err_seen && !beat.err;
    end
endmodule

// File: rtl/da_filter.sv
module da_filter
    import da_filt_pkg::*;
#(
    parameter mac_t STATION_ADDR = 48'h000A3502AF9A
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] rx_byte,
    input  logic       rx_byte_valid,
    input  logic       frame_start,
    input  logic       frame_end,
    input  logic       rx_err,
    output logic       frame_valid
);
    rx_beat_t           beat;
    pos_t               pos_cnt;
    logic [NUM_PAT-1:0] hits;

    assign beat = '{start: frame_start, fin: frame_end, vld: rx_byte_valid,
                    err: rx_err, data: rx_byte};

    da_pos_counter u_pos (
        .clk  (clk),
        .rst  (rst),
        .beat (beat),
        .pos  (pos_cnt)
    );

    for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
        localparam mac_t PAT = (g == 0) ? STATION_ADDR : BCAST_ADDR;
        da_pattern_track #(.PATTERN(PAT)) u_trk (
            .clk  (clk),
            .rst  (rst),
            .beat (beat),
            .pos  (pos_cnt),
            .hit  (hits[g])
        );
    end

    da_verdict u_verdict (
        .clk         (clk),
        .rst         (rst),
        .beat        (beat),
        .pos         (pos_cnt),
        .hit_any     (|hits),
        .frame_valid (frame_valid)
    );
endmodule

// File: rtl/da_filter_chk.sv
module da_filter_chk
    import da_filt_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic frame_end,
    input logic rx_err,
    input logic frame_valid,
    input pos_t byte_cnt
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !frame_valid);

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid |=> !frame_valid);

    // R9
    after_end_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> $past(frame_end));

    // R5
    no_err_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> !$past(rx_err));

    // R6
    full_addr_chk: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> ($past(byte_cnt) == ADDR_DONE));
endmodule

bind da_filter da_filter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_end   (frame_end),
    .rx_err      (rx_err),
    .frame_valid (frame_valid),
    .byte_cnt    (pos_cnt)
);

// File: tb/sim_da_filter.sv
`timescale 1ns/1ps
module sim_da_filter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_byte = '0;
    logic       rx_byte_valid = 1'b0;
    logic       frame_start = 1'b0;
    logic       frame_end = 1'b0;
    logic       rx_err = 1'b0;
    logic       frame_valid;

    int total = 0;
    int bad   = 0;

    typedef struct { bit exp; string tag; } exp_t;
    exp_t sb[$];

    localparam logic [47:0] ME    = 48'h000A3502AF9A;
    localparam logic [47:0] BCAST = 48'hFFFFFFFFFFFF;

    always #2 clk = ~clk;

    da_filter u0 (
        .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid),
        .frame_start(frame_start), .frame_end(frame_end), .rx_err(rx_err),
        .frame_valid(frame_valid)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        rx_byte_valid = 0; frame_start = 0; frame_end = 0; rx_err = 0;
    endtask

    // err_at: byte index with error, -1 none, -2 on the end strobe
    task automatic send_frame(input logic [47:0] dst, input int n_dst,
                              input int n_extra, input logic [7:0] fill,
                              input int err_at, input bit gaps, input bit do_end,
                              input bit exp, input string tag);
        int idx;
        idx = 0;
        idle(); frame_start = 1; step(); idle();
        for (int i = 0; i < n_dst + n_extra; i++) begin
            rx_byte = (i < n_dst) ? dst[8*(5-i) +: 8] : fill;
            rx_byte_valid = 1;
            rx_err = (idx == err_at);
            idx++;
            step(); idle();
            if (gaps) step();
        end
        if (do_end) begin
            frame_end = 1;
            rx_err = (err_at == -2);
            sb.push_back('{exp, tag});
            step(); idle();
            step();
        end
    endtask

    task automatic lone_end(input string tag);
        idle(); frame_end = 1;
        sb.push_back('{1'b0, tag});
        step(); idle(); step();
    endtask

    // monitor: compare one cycle after every sampled end strobe
    bit prev_end = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_end) begin
                if (sb.size() == 0) begin
                    total++; bad++;
                    $display("FAIL scoreboard empty: frame_valid=%0b expected entry", frame_valid);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    total++;
                    if (frame_valid !== e.exp) begin
                        bad++;
                        $display("FAIL %s: frame_valid=%0b expected %0b", e.tag, frame_valid, e.exp);
                    end
                end
            end else if (frame_valid !== 1'b0) begin
                total++; bad++;
                $display("FAIL R2 stray pulse: frame_valid=%0b expected 0", frame_valid);
            end
        end
        prev_end = frame_end;
    end

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog: run hung, finished=0 expected 1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(); step();
        #1;
        total++;
        if (frame_valid !== 1'b0) begin bad++; $display("FAIL R1: frame_valid=%0b expected 0", frame_valid); end
        rst = 0;
        step();
        total++;
        if (frame_valid !== 1'b0) begin bad++; $display("FAIL R1 post: frame_valid=%0b expected 0", frame_valid); end

        lone_end("R9 end without start");
        send_frame(ME, 6, 8, 8'h45, -1, 0, 1, 1, "R2 unicast");
        send_frame(BCAST, 6, 4, 8'h00, -1, 0, 1, 1, "R3 broadcast");
        send_frame(ME ^ 48'h1, 6, 4, 8'h11, -1, 0, 1, 0, "R4 last byte differs");
        send_frame(48'h010A3502AF9A, 6, 2, 8'h22, -1, 0, 1, 0, "R4 first byte differs");
        send_frame(ME, 6, 4, 8'h33, 2, 0, 1, 0, "R5 error in address");
        send_frame(ME, 6, 4, 8'h33, 8, 0, 1, 0, "R5 error in payload");
        send_frame(ME, 6, 2, 8'h33, -2, 0, 1, 0, "R5 error on end");
        send_frame(ME, 5, 0, 8'h00, -1, 0, 1, 0, "R6 five bytes");
        send_frame(BCAST, 6, 0, 8'h00, -1, 0, 1, 1, "R6 exactly six bytes");
        send_frame(ME, 6, 6, 8'hFF, -1, 0, 1, 1, "R7 payload ignored");
        send_frame(48'h112233445566, 3, 0, 8'h00, -1, 0, 0, 0, "R8 aborted");
        send_frame(ME, 6, 3, 8'h08, -1, 0, 1, 1, "R8 restart accepted");
        lone_end("R9 second end");
        send_frame(ME, 6, 3, 8'h5A, -1, 1, 1, 1, "R10 gapped bytes");
        send_frame(48'h000AFFFFFFFF, 6, 2, 8'h00, -1, 0, 1, 0, "R11 mixed pattern");
        send_frame(48'hFFFF3502AF9A, 6, 2, 8'h00, -1, 1, 1, 0, "R11 mixed pattern gapped");

        step(); step();
        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL R2 pending: left=%0d expected 0", sb.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule